// File: doc/BRIEF.md
# Concatenable PWM Channel Pair

This block holds two pulse-width channels of `CH_W` bits each. They share one clock prescaler and a small register write port. With the join bit clear, each channel runs as its own PWM. Each has its own period, duty, polarity, alignment mode, clock choice and enable. With the join bit set, the two period registers and the two duty registers combine into one PWM of twice the width. The even channel supplies the upper half and the odd channel the lower half. The joined waveform appears only on the odd pin, and only the odd channel's mode bits steer it.

The prescaler offers two tick rates to the channels. The fast tick fires on every cycle that the prescaler runs. The slow tick fires once every `2**PRE_LOG2` running cycles. Two control bits can stop the prescaler: one in wait mode, one in freeze mode. While it is stopped the counters hold still, but the registers can still be written. New period and duty values are held in shadow registers and applied only at a period boundary or when a channel is enabled.

Top module: `pwm_pair`

## Requirements
- R1: Left-aligned mode (align bit 0, fast clock): an enabled channel with period P and duty D, where 0 < D < P, repeats a run of D cycles at its polarity level followed by P-D cycles at the opposite level.
- R2: Center-aligned mode (align bit 1): under the same conditions the pattern is a run of 2·D active cycles followed by 2·(P-D) inactive cycles.
- R3: While a channel is enabled, duty 0 holds its pin at the inverse of its polarity bit, and a duty of at least P holds the pin at the polarity level.
- R4: A disabled channel drives its pin low, and both pins are low after reset.
- R5: Clock-select bit 0 advances a channel on every running prescaler cycle. Bit 1 advances it once every 2**PRE_LOG2 running cycles, which stretches every run by that factor.
- R6: With the join bit set, the PWM uses period {per_even, per_odd} and duty {duty_even, duty_odd}. Its output is on the odd pin, and the even pin stays low.
- R7: In joined mode the even channel's polarity, align and clock-select bits have no effect on the output.
- R8: A write to the join bit is dropped while either enable bit is set. The stop bits in the same write still take effect.
- R9: With stop-in-wait set and wait_mode high, the counters and pins hold still. With stop-in-wait clear, wait_mode has no effect.
- R10: With stop-in-freeze set and freeze_mode high, the counters hold. Register writes still take effect, for example a polarity change inverts the held pin. The waveform resumes once freeze is released.
- R11: A duty written in the middle of a period leaves the current period unchanged and applies from the next period.
- R12: Register map (wr_addr, byte write on wr_data):
  - address 0: bit0 join, bit1 stop-in-wait, bit2 stop-in-freeze
  - address 1: enables
  - address 2: polarity
  - address 3: align
  - address 4: clock select
  - addresses 5 and 6: period for the even and odd channel
  - addresses 7 and 8: duty for the even and odd channel
  - In the bit-per-channel registers (addresses 1 to 4), bit0 is the even channel and bit1 the odd channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CH_W | Write data |
| wait_mode | input | 1 | Wait-mode indication |
| freeze_mode | input | 1 | Freeze-mode indication |
| pwm_even | output | 1 | Even channel pin (low when joined) |
| pwm_odd | output | 1 | Odd channel pin (joined output) |

## Verification
The bench sweeps period and duty over both channels, both polarities and both alignments. It measures the active and inactive run lengths, which exposes an off-by-one wrap: such a design would stretch or shorten every period by one count. A center counter that dwells twice at an end point would show up as one run being one cycle longer than the other. In joined mode the bench gives the even channel contrary mode bits and uses a 16-bit period. A design that read the even controls, or that split the counter wrongly, would show runs other than 129 cycles or activity on the even pin. The bench also writes a duty in the middle of a period to catch an unshadowed update that cuts the current pulse. It tries to clear the join bit while the channels run, and it toggles both stop bits to confirm that the waveform freezes and then resumes.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_EN     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_POL    = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_ALIGN  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CLKSEL = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_PER0   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_PER1   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_DUTY0  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_DUTY1  = 4'd8;
  localparam int CTRL_JOIN = 0;
  localparam int CTRL_SWAI = 1;
  localparam int CTRL_SFRZ = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick_fast,
  output logic tick_slow
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end

  assign tick_fast = run;
  assign tick_slow = run && (div_q == '1);
endmodule

// File: rtl/pwm_engine.sv
module pwm_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic         center,
  input  logic         pol,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  output logic         out_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, per_s, duty_s;
  logic         down_q, en_d, out_q;
  logic [W-1:0] cnt_inc, cnt_dec;
  logic         active;

  assign cnt_inc = cnt_q + 1'b1;
  assign cnt_dec = cnt_q - 1'b1;
  // descending half compares inclusively so both halves give duty-length runs
  assign active  = down_q ? (cnt_q <= duty_s) : (cnt_q < duty_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      per_s  <= '0;
      duty_s <= '0;
      down_q <= 1'b0;
      en_d   <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      en_d  <= en;
      out_q <= en ? (active ? pol : ~pol) : 1'b0;
      if (!en) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
      end else if (!en_d) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
        per_s  <= per;
        duty_s <= duty;
      end else if (tick) begin
        if (!center) begin
          if (cnt_inc >= per_s) begin
            cnt_q  <= '0;
            per_s  <= per;
            duty_s <= duty;
          end else begin
            cnt_q <= cnt_inc;
          end
        end else if (per_s == '0) begin
          cnt_q  <= '0;
          per_s  <= per;
          duty_s <= duty;
        end else if (!down_q) begin
          cnt_q <= cnt_inc;
          if (cnt_inc == per_s) down_q <= 1'b1;
        end else begin
          cnt_q <= cnt_dec;
          if (cnt_dec == '0) begin
            down_q <= 1'b0;
            per_s  <= per;
            duty_s <= duty;
          end
        end
      end
    end
  end

  assign out_o = out_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int PRE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CH_W-1:0]   wr_data,
  input  logic              wait_mode,
  input  logic              freeze_mode,
  output logic              pwm_even,
  output logic              pwm_odd
);
  localparam int WIDE_W = 2 * CH_W;

  logic            concat_q, stop_wait_q, stop_frz_q;
  logic [1:0]      en_q, pol_q, center_q, clksel_q;
  logic [CH_W-1:0] per_q  [2];
  logic [CH_W-1:0] duty_q [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      concat_q    <= 1'b0;
      stop_wait_q <= 1'b0;
      stop_frz_q  <= 1'b0;
      en_q        <= '0;
      pol_q       <= '0;
      center_q    <= '0;
      clksel_q    <= '0;
      per_q       <= '{default: '0};
      duty_q      <= '{default: '0};
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          if (en_q == 2'b00) concat_q <= wr_data[CTRL_JOIN];
          stop_wait_q <= wr_data[CTRL_SWAI];
          stop_frz_q  <= wr_data[CTRL_SFRZ];
        end
        ADR_EN:     en_q      <= wr_data[1:0];
        ADR_POL:    pol_q     <= wr_data[1:0];
        ADR_ALIGN:  center_q  <= wr_data[1:0];
        ADR_CLKSEL: clksel_q  <= wr_data[1:0];
        ADR_PER0:   per_q[0]  <= wr_data;
        ADR_PER1:   per_q[1]  <= wr_data;
        ADR_DUTY0:  duty_q[0] <= wr_data;
        ADR_DUTY1:  duty_q[1] <= wr_data;
        default: ;
      endcase
    end
  end

  logic presc_run, tick_fast, tick_slow;
  assign presc_run = !(stop_wait_q && wait_mode) && !(stop_frz_q && freeze_mode);

  pwm_prescaler #(.DIV_LOG2(PRE_LOG2)) u_presc (
    .clk       (clk),
    .rst       (rst),
    .run       (presc_run),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow)
  );

  logic [1:0] tick;
  for (genvar c = 0; c < 2; c++) begin : g_tick
    assign tick[c] = clksel_q[c] ? tick_slow : tick_fast;
  end

  logic              en_even;
  logic [CH_W-1:0]   cnt_even;
  logic [WIDE_W-1:0] per_wide, duty_wide, cnt_odd;

  assign en_even   = en_q[0] && !concat_q;
  assign per_wide  = concat_q ? {per_q[0], per_q[1]}  : {{CH_W{1'b0}}, per_q[1]};
  assign duty_wide = concat_q ? {duty_q[0], duty_q[1]} : {{CH_W{1'b0}}, duty_q[1]};

  pwm_engine #(.W(CH_W)) u_even (
    .clk    (clk),
    .rst    (rst),
    .en     (en_even),
    .tick   (tick[0]),
    .center (center_q[0]),
    .pol    (pol_q[0]),
    .per    (per_q[0]),
    .duty   (duty_q[0]),
    .out_o  (pwm_even),
    .cnt_o  (cnt_even)
  );

  pwm_engine #(.W(WIDE_W)) u_odd (
    .clk    (clk),
    .rst    (rst),
    .en     (en_q[1]),
    .tick   (tick[1]),
    .center (center_q[1]),
    .pol    (pol_q[1]),
    .per    (per_wide),
    .duty   (duty_wide),
    .out_o  (pwm_odd),
    .cnt_o  (cnt_odd)
  );
endmodule

// File: rtl/pwm_pair_checker.sv
module pwm_pair_checker #(
  parameter int CH_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wait_mode,
  input logic              freeze_mode,
  input logic              stop_wait_q,
  input logic              stop_frz_q,
  input logic              concat_q,
  input logic [1:0]        en_q,
  input logic              pwm_even,
  input logic              pwm_odd,
  input logic [CH_W-1:0]   cnt_even,
  input logic [2*CH_W-1:0] cnt_odd
);
  // R6: even pin is silent while joined
  p_even_low_joined_r6: assert property (@(posedge clk) disable iff (rst)
    concat_q |=> !pwm_even);

  // R8: join bit cannot move while a channel is enabled
  p_join_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (en_q != 2'b00) |=> $stable(concat_q));

  // R9: counters hold while stopped in wait mode
  p_wait_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_wait_q && wait_mode && $stable(en_q)) |=> ($stable(cnt_even) && $stable(cnt_odd)));

  // R10: counters hold while stopped in freeze mode
  p_freeze_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (stop_frz_q && freeze_mode && $stable(en_q)) |=> ($stable(cnt_even) && $stable(cnt_odd)));

  // R4: disabled channels drive low
  p_odd_off_low_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q[1] |=> !pwm_odd);
  p_even_off_low_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q[0] |=> !pwm_even);
endmodule

bind pwm_pair pwm_pair_checker #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wait_mode   (wait_mode),
  .freeze_mode (freeze_mode),
  .stop_wait_q (stop_wait_q),
  .stop_frz_q  (stop_frz_q),
  .concat_q    (concat_q),
  .en_q        (en_q),
  .pwm_even    (pwm_even),
  .pwm_odd     (pwm_odd),
  .cnt_even    (cnt_even),
  .cnt_odd     (cnt_odd)
);

// File: tb/pwm_pair_tb_top.sv
module pwm_pair_tb_top;
  import pwm_pair_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W       = 8;
  localparam int PRE_LOG2   = 2;
  localparam int SLOW       = 1 << PRE_LOG2;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_en = 1'b0;
  logic [3:0]      wr_addr = '0;
  logic [CH_W-1:0] wr_data = '0;
  logic            wait_mode = 1'b0;
  logic            freeze_mode = 1'b0;
  logic            pwm_even, pwm_odd;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pair #(.CH_W(CH_W), .PRE_LOG2(PRE_LOG2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wait_mode(wait_mode), .freeze_mode(freeze_mode),
    .pwm_even(pwm_even), .pwm_odd(pwm_odd)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CH_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic pin(input bit ch);
    return ch ? pwm_odd : pwm_even;
  endfunction

  // measure one full active run and the following inactive run
  task automatic measure(input bit ch, input bit lvl, output int h, output int l);
    int n;
    h = -1; l = -1; n = 0;
    repeat (3) @(negedge clk);
    while (pin(ch) == lvl && n < 3000) begin @(negedge clk); n++; end
    while (pin(ch) != lvl && n < 6000) begin @(negedge clk); n++; end
    if (n >= 6000) return;
    h = 0;
    while (pin(ch) == lvl && h < 3000) begin h++; @(negedge clk); end
    l = 0;
    while (pin(ch) != lvl && l < 3000) begin l++; @(negedge clk); end
  endtask

  task automatic changes(input bit ch, input int cycles, output int c);
    logic prev;
    c = 0;
    @(negedge clk);
    prev = pin(ch);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pin(ch) != prev) c++;
      prev = pin(ch);
    end
  endtask

  task automatic setup(input bit ch, input bit pol, input bit ctr, input bit cks,
                       input int per, input int duty);
    wr(ADR_EN, 0);
    wr(ADR_POL, int'(pol) << ch);
    wr(ADR_ALIGN, int'(ctr) << ch);
    wr(ADR_CLKSEL, int'(cks) << ch);
    wr(ch ? ADR_PER1 : ADR_PER0, per);
    wr(ch ? ADR_DUTY1 : ADR_DUTY0, duty);
    wr(ADR_EN, 1 << ch);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int h, l, c;
    logic p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R4 reset even pin", int'(pwm_even), 0);
    check("R4 reset odd pin", int'(pwm_odd), 0);

    // R1 R2 R12: sweep channels, polarity, alignment, period, duty
    for (int ch = 0; ch < 2; ch++)
      for (int ctr = 0; ctr < 2; ctr++)
        for (int pol = 0; pol < 2; pol++)
          for (int per = 2; per <= 5; per++)
            for (int d = 1; d < per; d++) begin
              setup(ch[0], pol[0], ctr[0], 1'b0, per, d);
              measure(ch[0], pol[0], h, l);
              if (ctr == 0) begin
                check($sformatf("R1 active ch%0d pol%0d P%0d D%0d", ch, pol, per, d), h, d);
                check($sformatf("R1 inactive ch%0d pol%0d P%0d D%0d", ch, pol, per, d), l, per - d);
              end else begin
                check($sformatf("R2 active ch%0d pol%0d P%0d D%0d", ch, pol, per, d), h, 2 * d);
                check($sformatf("R2 inactive ch%0d pol%0d P%0d D%0d", ch, pol, per, d), l, 2 * (per - d));
              end
            end

    // R3: duty extremes
    for (int pol = 0; pol < 2; pol++) begin
      setup(1'b1, pol[0], 1'b0, 1'b0, 3, 0);
      repeat (4) @(negedge clk);
      c = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_odd != !pol[0]) c++; end
      check($sformatf("R3 duty 0 pol%0d off-level cycles", pol), c, 0);
      setup(1'b0, pol[0], 1'b1, 1'b0, 3, 4);
      repeat (4) @(negedge clk);
      c = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_even != pol[0]) c++; end
      check($sformatf("R3 duty>=per pol%0d off-level cycles", pol), c, 0);
    end

    // R4: disable drives low
    wr(ADR_POL, 3);
    wr(ADR_EN, 0);
    repeat (2) @(negedge clk);
    check("R4 disabled odd low", int'(pwm_odd), 0);
    check("R4 disabled even low", int'(pwm_even), 0);

    // R5: slow clock
    setup(1'b1, 1'b1, 1'b0, 1'b1, 3, 1);
    measure(1'b1, 1'b1, h, l);
    check("R5 slow active", h, 1 * SLOW);
    check("R5 slow inactive", l, 2 * SLOW);

    // R6 R7: joined 16-bit, even controls contrary and ignored
    wr(ADR_EN, 0);
    wr(ADR_CTRL, 1);
    wr(ADR_PER0, 1); wr(ADR_PER1, 2);
    wr(ADR_DUTY0, 0); wr(ADR_DUTY1, 129);
    wr(ADR_POL, 2); wr(ADR_ALIGN, 1); wr(ADR_CLKSEL, 1);
    wr(ADR_EN, 3);
    measure(1'b1, 1'b1, h, l);
    check("R6 joined active", h, 129);
    check("R7 joined inactive", l, 129);
    changes(1'b0, 300, c);
    check("R6 even pin quiet when joined", c + int'(pwm_even), 0);

    // R8: clearing join while enabled is dropped
    wr(ADR_CTRL, 0);
    measure(1'b1, 1'b1, h, l);
    check("R8 still joined active", h, 129);
    check("R8 still joined inactive", l, 129);
    wr(ADR_EN, 0);
    wr(ADR_CTRL, 0);

    // R9: wait mode
    setup(1'b1, 1'b1, 1'b0, 1'b0, 4, 2);
    wr(ADR_CTRL, 2);
    wait_mode = 1'b1;
    repeat (3) @(negedge clk);
    changes(1'b1, 40, c);
    check("R9 held in wait", c, 0);
    wr(ADR_CTRL, 0);
    changes(1'b1, 40, c);
    check("R9 runs in wait when bit clear", int'(c >= 18), 1);
    wait_mode = 1'b0;

    // R10: freeze mode, writes still land
    wr(ADR_CTRL, 4);
    freeze_mode = 1'b1;
    repeat (3) @(negedge clk);
    changes(1'b1, 40, c);
    check("R10 held in freeze", c, 0);
    p = pwm_odd;
    wr(ADR_POL, 0);
    repeat (2) @(negedge clk);
    check("R10 polarity write lands while frozen", int'(pwm_odd), int'(!p));
    wr(ADR_POL, 2);
    freeze_mode = 1'b0;
    measure(1'b1, 1'b1, h, l);
    check("R10 resumed active", h, 2);
    check("R10 resumed inactive", l, 2);

    // R11: duty change mid-period
    setup(1'b1, 1'b1, 1'b0, 1'b0, 6, 2);
    repeat (3) @(negedge clk);
    while (pwm_odd == 1'b1) @(negedge clk);
    while (pwm_odd == 1'b0) @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_DUTY1; wr_data = CH_W'(4);
    h = 1;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm_odd == 1'b1 && h < 100) begin h++; @(negedge clk); end
    check("R11 current period keeps old duty", h, 2);
    measure(1'b1, 1'b1, h, l);
    check("R11 next period new duty active", h, 4);
    check("R11 next period new duty inactive", l, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule